// File: doc/BRIEF.md
# Hinted Branch Direction Predictor

This block predicts whether a conditional branch will be taken, steered by a 2-bit hint that travels with each branch. Two hint values are static: they fix the prediction outright and never touch the learning table. The other two values are dynamic: they consult a direct-mapped, tagged table of saturating counters. When no matching entry exists, the prediction falls back to the direction named by the hint.

The predict port is combinational. The fetch stage presents an address and a hint and reads `pred_taken` in the same cycle. The update port is written at the clock edge. Resolved branches are reported with their address, their hint and their real outcome. A dynamic-hinted branch that misses in the table claims the entry at its index. The new entry's counter starts at the weak state on the side of the outcome. Hints only steer the prediction and never change functional results. A parameter can build a variant that ignores hints and treats every branch as dynamic.

Top module: `hint_branch_predictor`

## Requirements
- R1: After reset every table entry is invalid, so every dynamic-hinted prediction equals the hint's default direction.
- R2: Hint code 2'b00 (static not-taken) always predicts not-taken, whatever the table holds for that address.
- R3: Hint code 2'b01 (static taken) always predicts taken, whatever the table holds for that address.
- R4: An update carrying a static hint (2'b00 or 2'b01) changes no table entry, and it does not allocate one.
- R5: A dynamic-hinted prediction that misses the table is not-taken for hint 2'b10 (dynamic not-taken) and taken for hint 2'b11 (dynamic taken).
- R6: A dynamic-hinted update that misses allocates the entry at its index with its tag. The entry's counter starts at weak-taken (2'b10) if the branch was taken, and at weak-not-taken (2'b01) otherwise.
- R7: A dynamic-hinted update that hits moves the 2-bit counter up on taken and down on not-taken, saturating at 2'b11 and 2'b00. A dynamic prediction that hits returns the counter's upper bit.
- R8: An entry whose tag differs from the branch's tag is a miss. A dynamic update from the other branch replaces it.
- R9: A prediction and an update to the same index in the same cycle return the value held before that update.
- R10: The index is address bits [7:2] and the tag is formed from bits [31:8]. Address bits [1:0] do not affect the prediction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_addr | input | 32 | Address of the branch being predicted |
| pred_hint | input | 2 | Hint of the branch being predicted (00 SNT, 01 STK, 10 DNT, 11 DTK) |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | An update is presented this cycle |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_hint | input | 2 | Hint carried by the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The hardest situation to reach from the ports is a prediction and an update landing on the same index in one cycle. The stimulus gets there by driving both ports in the same low clock phase. It samples `pred_taken` before the edge and again after it, once for a hit entry that flips direction and once for an allocating miss. Proving that static updates leave the table alone is also indirect. The bench first trains an entry to a strong state. It then floods that entry with opposing static updates and reads the entry back with a dynamic hint whose default disagrees with the stored counter.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

   typedef enum logic [1:0] {
      HINT_SNT = 2'b00,
      HINT_STK = 2'b01,
      HINT_DNT = 2'b10,
      HINT_DTK = 2'b11
   } hint_e;

   function automatic logic hint_is_dynamic(input logic [1:0] h);
      return h[1];
   endfunction

   function automatic logic hint_default_dir(input logic [1:0] h);
      return h[0];
   endfunction

endpackage

// File: rtl/hbp_addr_split.sv
module hbp_addr_split #(
   parameter int ADDR_W    = 32,
   parameter int ALIGN_LSB = 2,
   parameter int IDX_W     = 6,
   parameter int TAG_W     = 10,
   parameter bit FOLD_TAG  = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic [TAG_W-1:0]  tag
);
   localparam int HI_LSB = ALIGN_LSB + IDX_W;
   localparam int HI_W   = ADDR_W - HI_LSB;

   logic [HI_W-1:0] hi_bits;

   assign idx     = addr[ALIGN_LSB +: IDX_W];
   assign hi_bits = addr[ADDR_W-1:HI_LSB];

   generate
      if (ALIGN_LSB > 0) begin : g_lo
         logic unused_lo;
         assign unused_lo = ^addr[ALIGN_LSB-1:0];
      end

      if (FOLD_TAG) begin : g_fold
         always_comb begin
            tag = '0;
            for (int i = 0; i < HI_W; i++) begin
               tag[i % TAG_W] = tag[i % TAG_W] ^ hi_bits[i];
            end
         end
      end else begin : g_trunc
         assign tag = hi_bits[TAG_W-1:0];
         if (HI_W > TAG_W) begin : g_drop
            logic unused_hi;
            assign unused_hi = ^hi_bits[HI_W-1:TAG_W];
         end
      end
   endgenerate

endmodule

// File: rtl/hbp_table.sv
module hbp_table #(
   parameter int IDX_W = 6,
   parameter int TAG_W = 10,
   parameter int CTR_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             rd_hit,
   output logic [CTR_W-1:0] rd_ctr,
   input  logic             wr_req,
   input  logic             wr_dyn,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             wr_taken
);
   localparam int              ENTRIES = 1 << IDX_W;
   localparam logic [CTR_W-1:0] CTR_MAX = '1;
   localparam logic [CTR_W-1:0] CTR_MIN = '0;
   localparam logic [CTR_W-1:0] WEAK_T  = {1'b1, {(CTR_W-1){1'b0}}};
   localparam logic [CTR_W-1:0] WEAK_NT = {1'b0, {(CTR_W-1){1'b1}}};

   logic [ENTRIES-1:0]            valid_q;
   logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
   logic [ENTRIES-1:0][CTR_W-1:0] ctr_q;

   logic             wr_hit;
   logic             wr_en;
   logic [CTR_W-1:0] wr_cur;
   logic [CTR_W-1:0] wr_next;

   // read port: combinational, sees state before any same-cycle write
   assign rd_hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
   assign rd_ctr = ctr_q[rd_idx];

   // write port
   assign wr_hit = valid_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
   assign wr_cur = ctr_q[wr_idx];
   assign wr_en  = wr_req && wr_dyn;

   always_comb begin
      if (!wr_hit) begin
         wr_next = wr_taken ? WEAK_T : WEAK_NT;
      end else if (wr_taken) begin
         wr_next = (wr_cur == CTR_MAX) ? wr_cur : wr_cur + 1'b1;
      end else begin
         wr_next = (wr_cur == CTR_MIN) ? wr_cur : wr_cur - 1'b1;
      end
   end

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               valid_q[e] <= 1'b0;
               tag_q[e]   <= '0;
               ctr_q[e]   <= WEAK_NT;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
               valid_q[e] <= 1'b1;
               tag_q[e]   <= wr_tag;
               ctr_q[e]   <= wr_next;
            end
         end
      end
   endgenerate

   // R4: static-hinted updates leave the whole table untouched
   a_r4_static_keeps_table: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_dyn) |=> ($stable(valid_q) && $stable(tag_q) && $stable(ctr_q)));

   // R6: a missing dynamic update allocates a weak entry on the outcome's side
   a_r6_alloc_weak: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_hit) |=>
         (valid_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag)) &&
          (ctr_q[$past(wr_idx)] == ($past(wr_taken) ? WEAK_T : WEAK_NT))));

   // R7: saturation at the top
   a_r7_saturate_top: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_hit && wr_taken && (wr_cur == CTR_MAX)) |=>
         (ctr_q[$past(wr_idx)] == CTR_MAX));

   // R7: saturation at the bottom
   a_r7_saturate_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_hit && !wr_taken && (wr_cur == CTR_MIN)) |=>
         (ctr_q[$past(wr_idx)] == CTR_MIN));

   // R1: reset leaves no valid entry
   a_r1_reset_empty: assert property (@(posedge clk)
      (!rst_n) |=> (valid_q == '0));

endmodule

// File: rtl/hbp_decide.sv
module hbp_decide
   import hbp_pkg::*;
#(
   parameter int CTR_W       = 2,
   parameter bit HONOR_HINTS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       hint,
   input  logic             hit,
   input  logic [CTR_W-1:0] ctr,
   output logic             taken
);
   generate
      if (HONOR_HINTS) begin : g_honor
         always_comb begin
            if (hint_is_dynamic(hint) && hit) begin
               taken = ctr[CTR_W-1];
            end else begin
               taken = hint_default_dir(hint);
            end
         end

         // R2: static not-taken is never overridden by the table
         a_r2_snt_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
            (hint == HINT_SNT) |-> !taken);

         // R3: static taken is never overridden by the table
         a_r3_stk_taken: assert property (@(posedge clk) disable iff (!rst_n)
            (hint == HINT_STK) |-> taken);

         // R5: dynamic miss follows the hint's direction
         a_r5_miss_default: assert property (@(posedge clk) disable iff (!rst_n)
            (hint_is_dynamic(hint) && !hit) |-> (taken == (hint == HINT_DTK)));
      end else begin : g_ignore
         logic unused_hint;
         assign unused_hint = ^hint;
         assign taken = hit ? ctr[CTR_W-1] : 1'b1;
      end
   endgenerate

endmodule

// File: rtl/hint_branch_predictor.sv
module hint_branch_predictor
   import hbp_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int ALIGN_LSB   = 2,
   parameter int IDX_W       = 6,
   parameter int TAG_W       = 10,
   parameter int CTR_W       = 2,
   parameter bit FOLD_TAG    = 1'b1,
   parameter bit HONOR_HINTS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] pred_addr,
   input  logic [1:0]        pred_hint,
   output logic              pred_taken,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic [1:0]        upd_hint,
   input  logic              upd_taken
);
   localparam int USED_W = ALIGN_LSB + IDX_W + TAG_W;

   generate
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("hint_branch_predictor: IDX_W must be within 1..12");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("hint_branch_predictor: TAG_W must be at least 1");
      end
      if (CTR_W < 2) begin : g_bad_ctr
         $error("hint_branch_predictor: CTR_W must be at least 2");
      end
      if (USED_W > ADDR_W) begin : g_bad_addr
         $error("hint_branch_predictor: ALIGN_LSB + IDX_W + TAG_W exceeds ADDR_W");
      end
   endgenerate

   logic [IDX_W-1:0] p_idx, u_idx;
   logic [TAG_W-1:0] p_tag, u_tag;
   logic             p_hit;
   logic [CTR_W-1:0] p_ctr;
   logic             u_dyn;

   hbp_addr_split #(
      .ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB), .IDX_W(IDX_W),
      .TAG_W(TAG_W), .FOLD_TAG(FOLD_TAG)
   ) u_pred_split (
      .addr(pred_addr), .idx(p_idx), .tag(p_tag)
   );

   hbp_addr_split #(
      .ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB), .IDX_W(IDX_W),
      .TAG_W(TAG_W), .FOLD_TAG(FOLD_TAG)
   ) u_upd_split (
      .addr(upd_addr), .idx(u_idx), .tag(u_tag)
   );

   generate
      if (HONOR_HINTS) begin : g_upd_honor
         assign u_dyn = hint_is_dynamic(upd_hint);
      end else begin : g_upd_ignore
         logic unused_upd_hint;
         assign unused_upd_hint = ^upd_hint;
         assign u_dyn = 1'b1;
      end
   endgenerate

   hbp_table #(
      .IDX_W(IDX_W), .TAG_W(TAG_W), .CTR_W(CTR_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(p_idx), .rd_tag(p_tag), .rd_hit(p_hit), .rd_ctr(p_ctr),
      .wr_req(upd_valid), .wr_dyn(u_dyn), .wr_idx(u_idx),
      .wr_tag(u_tag), .wr_taken(upd_taken)
   );

   hbp_decide #(
      .CTR_W(CTR_W), .HONOR_HINTS(HONOR_HINTS)
   ) u_decide (
      .clk(clk), .rst_n(rst_n),
      .hint(pred_hint), .hit(p_hit), .ctr(p_ctr), .taken(pred_taken)
   );

   // R9: a prediction at the index being written reflects pre-write state,
   // so a dynamic hit that flips the counter's upper bit is seen one cycle later
   a_r9_pre_update_read: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && u_dyn && (p_idx == u_idx) && (p_tag == u_tag) && p_hit &&
       hint_is_dynamic(pred_hint) && $stable(pred_addr)) |->
         (pred_taken == p_ctr[CTR_W-1]));

endmodule

// File: tb/hint_branch_predictor_bench.sv
module hint_branch_predictor_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pred_addr = '0;
   logic [1:0]  pred_hint = 2'b00;
   logic        pred_taken;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_addr = '0;
   logic [1:0]  upd_hint = 2'b00;
   logic        upd_taken = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   localparam logic [1:0] SNT = 2'b00;
   localparam logic [1:0] STK = 2'b01;
   localparam logic [1:0] DNT = 2'b10;
   localparam logic [1:0] DTK = 2'b11;

   always #2 clk = ~clk;   // 250 MHz

   hint_branch_predictor u_hint_branch_predictor (
      .clk(clk), .rst_n(rst_n),
      .pred_addr(pred_addr), .pred_hint(pred_hint), .pred_taken(pred_taken),
      .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_hint(upd_hint),
      .upd_taken(upd_taken)
   );

   function automatic logic [31:0] mk(input int tag, input int idx);
      return (32'(tag) << 8) | (32'(idx & 63) << 2);
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic pred_chk(input string req, input logic [31:0] a,
                           input logic [1:0] h, input logic exp);
      pred_addr = a;
      pred_hint = h;
      #1;
      check(req, pred_taken, exp);
   endtask

   task automatic upd(input logic [31:0] a, input logic [1:0] h, input logic t);
      @(negedge clk);
      upd_addr  = a;
      upd_hint  = h;
      upd_taken = t;
      upd_valid = 1'b1;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   task automatic t_reset_state;
      for (int i = 0; i < 64; i += 9) begin
         pred_chk("R1 reset DNT", mk(i + 3, i), DNT, 1'b0);
         pred_chk("R1 reset DTK", mk(i + 3, i), DTK, 1'b1);
      end
   endtask

   task automatic t_static_predict;
      logic [31:0] a_nt = mk(5, 1);
      logic [31:0] a_t  = mk(6, 2);
      upd(a_nt, DTK, 1'b0);
      upd(a_nt, DTK, 1'b0);   // 00
      upd(a_t,  DNT, 1'b1);
      upd(a_t,  DNT, 1'b1);   // 11
      pred_chk("R7 trained NT", a_nt, DTK, 1'b0);
      pred_chk("R7 trained T",  a_t,  DNT, 1'b1);
      pred_chk("R2 SNT over taken entry", a_t, SNT, 1'b0);
      pred_chk("R2 SNT on miss",  mk(7, 3), SNT, 1'b0);
      pred_chk("R3 STK over NT entry", a_nt, STK, 1'b1);
      pred_chk("R3 STK on miss",  mk(7, 3), STK, 1'b1);
   endtask

   task automatic t_static_no_alloc;
      logic [31:0] fresh = mk(9, 4);
      logic [31:0] held  = mk(10, 5);
      upd(fresh, SNT, 1'b1);
      upd(fresh, STK, 1'b0);
      pred_chk("R4 no alloc DNT", fresh, DNT, 1'b0);
      pred_chk("R4 no alloc DTK", fresh, DTK, 1'b1);
      upd(held, DNT, 1'b0);
      upd(held, DNT, 1'b0);   // 00
      for (int k = 0; k < 3; k++) upd(held, STK, 1'b1);
      upd(held, SNT, 1'b1);
      pred_chk("R4 entry unchanged", held, DTK, 1'b0);
      upd(held, DTK, 1'b1);   // 01 proves counter was still 00
      pred_chk("R4 counter kept strong", held, DTK, 1'b0);
   endtask

   task automatic t_allocate;
      logic [31:0] d = mk(11, 6);
      logic [31:0] e = mk(12, 7);
      pred_chk("R5 miss DNT", d, DNT, 1'b0);
      upd(d, DNT, 1'b1);      // 10
      pred_chk("R6 alloc weak taken", d, DNT, 1'b1);
      upd(d, DNT, 1'b0);      // 01
      pred_chk("R6 weak taken flips once", d, DTK, 1'b0);
      pred_chk("R5 miss DTK", e, DTK, 1'b1);
      upd(e, DTK, 1'b0);      // 01
      pred_chk("R6 alloc weak not-taken", e, DTK, 1'b0);
      upd(e, DTK, 1'b1);      // 10
      pred_chk("R6 weak not-taken flips once", e, DNT, 1'b1);
   endtask

   task automatic t_hysteresis;
      logic [31:0] f = mk(13, 8);
      upd(f, DTK, 1'b1);      // 10
      upd(f, DTK, 1'b1);      // 11
      upd(f, DTK, 1'b1);      // 11 saturated
      upd(f, DTK, 1'b0);      // 10
      pred_chk("R7 strong taken survives one NT", f, DNT, 1'b1);
      upd(f, DTK, 1'b0);      // 01
      pred_chk("R7 second NT flips", f, DTK, 1'b0);
      upd(f, DTK, 1'b0);      // 00
      upd(f, DTK, 1'b0);      // 00 saturated
      upd(f, DTK, 1'b1);      // 01
      pred_chk("R7 bottom saturates", f, DTK, 1'b0);
      upd(f, DTK, 1'b1);      // 10
      pred_chk("R7 climbs back", f, DNT, 1'b1);
   endtask

   task automatic t_alias;
      logic [31:0] a = mk(20, 9);
      logic [31:0] b = mk(21, 9);
      upd(a, DTK, 1'b0);
      upd(a, DTK, 1'b0);      // a: 00
      pred_chk("R8 other tag misses", b, DTK, 1'b1);
      upd(b, DTK, 1'b1);      // replaces with b: 10
      pred_chk("R8 replacement hits", b, DNT, 1'b1);
      pred_chk("R8 evicted tag misses", a, DTK, 1'b1);
      pred_chk("R8 evicted tag misses DNT", a, DNT, 1'b0);
   endtask

   task automatic t_same_cycle;
      logic [31:0] g = mk(30, 10);
      logic [31:0] n = mk(31, 11);
      upd(g, DTK, 1'b1);      // 10
      @(negedge clk);
      pred_addr = g; pred_hint = DNT;
      upd_addr = g; upd_hint = DNT; upd_taken = 1'b0; upd_valid = 1'b1;
      #1;
      check("R9 hit pre-update value", pred_taken, 1'b1);
      @(negedge clk);
      upd_valid = 1'b0;
      #1;
      check("R9 hit post-update value", pred_taken, 1'b0);
      @(negedge clk);
      pred_addr = n; pred_hint = DNT;
      upd_addr = n; upd_hint = DNT; upd_taken = 1'b1; upd_valid = 1'b1;
      #1;
      check("R9 miss pre-allocate value", pred_taken, 1'b0);
      @(negedge clk);
      upd_valid = 1'b0;
      #1;
      check("R9 miss post-allocate value", pred_taken, 1'b1);
   endtask

   task automatic t_align;
      logic [31:0] h = mk(40, 12);
      upd(h | 32'h3, DNT, 1'b1);  // low bits ignored on update
      pred_chk("R10 low bits 00", h, DNT, 1'b1);
      pred_chk("R10 low bits 11", h | 32'h3, DNT, 1'b1);
      pred_chk("R10 low bits 10", h | 32'h2, DNT, 1'b1);
      pred_chk("R10 index bits matter", mk(40, 13), DNT, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_static_predict();
      t_static_no_alloc();
      t_allocate();
      t_hysteresis();
      t_alias();
      t_same_cycle();
      t_align();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #40000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule